// File: doc/BRIEF.md
# Paced Single-Channel Memory Mover with Completion Chaining and Address Rings

This block is one transfer channel of a multi-channel mover. Software loads a source pointer, a destination pointer, an item count and a control word through a small word-indexed register port. A trigger starts the channel. The trigger is either a write to the source-pointer alias or a pulse on `chain_in` from another channel. The channel then copies the requested number of items over a simple request/acknowledge master bus, one item at a time. Each item is a read followed by a write.

Each item must wait for a pacing request. The control word selects the source: one of the external data-request lines, one of four timer tick inputs, or an always-on request for unpaced copies. Either pointer can advance by the item size or stay fixed, which is how a peripheral data register is addressed. One of the two pointers can wrap inside a power-of-two byte window, for example to replay a table forever. When the last item lands, the channel emits a one-cycle chain pulse that names the next channel to start, and an optional completion pulse. Software can stop a running channel through an abort register.

Top module: `dmac_chan`

## Requirements
- R1: After synchronous reset, `busy`, `m_req`, `chain_valid` and `done_irq` are low, and every readable register (indices 0-4 and 6) reads zero.
- R2: A write to index 4 loads the source pointer and starts the channel, provided control bit 0 (enable) is set and the programmed count (index 2) is nonzero. The channel then moves exactly that many items and drops `busy`. A trigger with the count at zero or with enable clear leaves `busy` low.
- R3: Control bits [2:1] select the item size: 0 is one byte, 1 is two bytes, 2 is four bytes. `m_size` carries the code. Data is right-aligned on `m_rdata` and `m_wdata`. Each item is one read, then one write of the captured data.
- R4: Control bit 3 lets the source pointer advance by the item size after each item. Control bit 4 does the same for the destination pointer. A cleared bit keeps that pointer fixed.
- R5: A nonzero code k in control bits [8:5] keeps the chosen pointer inside its aligned window of 2^k bytes, so its low k bits wrap and its upper bits stay fixed. Code 0 disables wrapping. Control bit 9 chooses the side: 0 wraps the source, 1 wraps the destination. The other pointer advances linearly.
- R6: On normal completion, `chain_valid` pulses for one cycle with `chain_id` equal to control bits [13:10], unless that field equals the channel's own number `CH_ID`, in which case no pulse is given. `done_irq` pulses in the same cycle unless control bit 20 is set.
- R7: A pulse on `chain_in` while idle acts as a trigger and uses the current source pointer.
- R8: Control bits [19:14] select the pacing source. Codes 0x00-0x3a select `dreq[code]`; codes at or above `NDREQ` never request. Codes 0x3b-0x3e select `timer_req[0..3]`. Code 0x3f requests permanently. No item's read begins without a pending request. A tick is held until the write of the item it released completes, and each tick releases one item.
- R9: A write to index 5 with bit `CH_ID` set stops a busy channel. A channel that is waiting for a request goes idle at the next edge. A channel in the middle of a bus access goes idle when that access is acknowledged. An aborted run gives no chain pulse and no completion pulse. Bits for other channels have no effect.
- R10: Writes to indices 0-4 are ignored while `busy` is high. Index 6 reads the remaining item count, and bit 31 of index 3 reads `busy`.
- R11: Each trigger reloads the remaining count from index 2. The pointers resume from where the previous run stopped unless software rewrites them.
- R12: Once `m_req` rises, it stays high with stable `m_addr` and `m_we` until the cycle in which `m_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| busy | output | 1 | Channel running |
| chain_in | input | 1 | Trigger from another channel |
| chain_valid | output | 1 | Completion pulse towards the named channel |
| chain_id | output | 4 | Channel to be started |
| done_irq | output | 1 | Completion pulse unless quieted |
| dreq | input | NDREQ | External data-request lines (level) |
| timer_req | input | 4 | Timer tick inputs (pulses) |
| m_req | output | 1 | Bus access request |
| m_we | output | 1 | 1 = write, 0 = read |
| m_addr | output | 32 | Byte address |
| m_size | output | 2 | Item size code |
| m_wdata | output | 32 | Write data, right-aligned |
| m_ack | input | 1 | Access complete |
| m_rdata | input | 32 | Read data, right-aligned, valid with `m_ack` |

## Verification
Some properties are checked on every cycle. The bus request holds steady until it is acknowledged. Any access the channel makes occurs while it reports busy. Each completed write lowers the remaining count by exactly one. A write is never followed directly by another write. A chain pulse lasts one cycle and never names the channel itself.

Other behaviours only the bench scenarios can show. These are the byte contents left in memory across size, increment and ring combinations; the pointer end values; the per-source pacing, including wrong-timer ticks; abort timing; ignored writes while busy; and pointer resumption across repeated chain triggers.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int REG_W  = 3;
    localparam int CTRL_W = 21;
    localparam int NTMR   = 4;

    // register word indices
    localparam logic [REG_W-1:0] IDX_SRC    = 3'd0;
    localparam logic [REG_W-1:0] IDX_DST    = 3'd1;
    localparam logic [REG_W-1:0] IDX_COUNT  = 3'd2;
    localparam logic [REG_W-1:0] IDX_CTRL   = 3'd3;
    localparam logic [REG_W-1:0] IDX_GO     = 3'd4;
    localparam logic [REG_W-1:0] IDX_KILL   = 3'd5;
    localparam logic [REG_W-1:0] IDX_REMAIN = 3'd6;

    localparam logic [5:0] PACE_TICK0 = 6'h3b;
    localparam logic [5:0] PACE_ALWAYS = 6'h3f;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_WRITE
    } mover_state_e;

    typedef struct packed {
        logic       quiet;
        logic [5:0] pace;
        logic [3:0] next_ch;
        logic       ring_dst;
        logic [3:0] ring_log2;
        logic       dst_inc;
        logic       src_inc;
        logic [1:0] size;
        logic       en;
    } mover_ctrl_t;

    function automatic logic [ADDR_W-1:0] bytes_per_item(input logic [1:0] size);
        case (size)
            2'd0:    return ADDR_W'(1);
            2'd1:    return ADDR_W'(2);
            default: return ADDR_W'(4);
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] next_ptr(
        input logic [ADDR_W-1:0] ptr,
        input logic [1:0]        size,
        input logic              inc,
        input logic              wrap_side,
        input logic [3:0]        ring_log2
    );
        logic [ADDR_W-1:0] sum;
        logic [ADDR_W-1:0] keep;
        if (!inc) return ptr;
        sum = ptr + bytes_per_item(size);
        if (wrap_side && ring_log2 != 4'd0) begin
            keep = (ADDR_W'(1) << ring_log2) - ADDR_W'(1);
            return (ptr & ~keep) | (sum & keep);
        end
        return sum;
    endfunction

endpackage

// File: rtl/dmac_cfg.sv
module dmac_cfg
    import dmac_pkg::*;
#(
    parameter int CH_ID = 0,
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [REG_W-1:0]    idx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                busy,
    output mover_ctrl_t         ctrl,
    output logic [CNT_W-1:0]    count_cfg,
    output logic                load_src,
    output logic                load_dst,
    output logic                go_sw,
    output logic                kill
);
    logic open_wr;
    assign open_wr = we && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            count_cfg <= '0;
        end else if (open_wr) begin
            if (idx == IDX_CTRL)  ctrl      <= mover_ctrl_t'(wdata[CTRL_W-1:0]);
            if (idx == IDX_COUNT) count_cfg <= wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        load_src = open_wr && (idx == IDX_SRC || idx == IDX_GO);
        load_dst = open_wr && (idx == IDX_DST);
        go_sw    = open_wr && (idx == IDX_GO);
        kill     = we && (idx == IDX_KILL) && wdata[CH_ID];
    end
endmodule

// File: rtl/dmac_pace.sv
module dmac_pace
    import dmac_pkg::*;
#(
    parameter int NDREQ = 59
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [5:0]       sel,
    input  logic [NDREQ-1:0] dreq,
    input  logic [NTMR-1:0]  ticks,
    input  logic             busy,
    input  logic             consume,
    output logic             ready
);
    logic req_now;
    logic held_q;

    always_comb begin
        req_now = 1'b0;
        if (sel == PACE_ALWAYS) begin
            req_now = 1'b1;
        end else begin
            for (int i = 0; i < NDREQ; i++)
                if (sel == 6'(i)) req_now = dreq[i];
            for (int t = 0; t < NTMR; t++)
                if (sel == PACE_TICK0 + 6'(t)) req_now = ticks[t];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !busy || consume) held_q <= 1'b0;
        else if (req_now)            held_q <= 1'b1;
    end

    assign ready = held_q || req_now;
endmodule

// File: rtl/dmac_xfer.sv
module dmac_xfer
    import dmac_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  mover_ctrl_t       ctrl,
    input  logic [CNT_W-1:0]  count_cfg,
    input  logic              load_src,
    input  logic              load_dst,
    input  logic [ADDR_W-1:0] ptr_wdata,
    input  logic              go_sw,
    input  logic              go_chain,
    input  logic              kill,
    input  logic              pace_ready,
    input  logic              m_ack,
    input  logic [DATA_W-1:0] m_rdata,
    output logic              busy,
    output logic [ADDR_W-1:0] src_ptr,
    output logic [ADDR_W-1:0] dst_ptr,
    output logic [CNT_W-1:0]  remain,
    output logic              m_req,
    output logic              m_we,
    output logic [ADDR_W-1:0] m_addr,
    output logic [1:0]        m_size,
    output logic [DATA_W-1:0] m_wdata,
    output logic              consume,
    output logic              finished
);
    mover_state_e      state_q;
    logic [DATA_W-1:0] hold_q;
    logic              kill_q;
    logic              launch, last_item, stopping;

    assign launch    = (go_sw || go_chain) && state_q == ST_IDLE && ctrl.en && count_cfg != '0;
    assign last_item = remain == CNT_W'(1);
    assign stopping  = kill || kill_q;
    assign consume   = state_q == ST_WRITE && m_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            src_ptr  <= '0;
            dst_ptr  <= '0;
            remain   <= '0;
            hold_q   <= '0;
            kill_q   <= 1'b0;
            finished <= 1'b0;
        end else begin
            finished <= 1'b0;
            if (load_src) src_ptr <= ptr_wdata;
            if (load_dst) dst_ptr <= ptr_wdata;
            case (state_q)
                ST_IDLE: begin
                    kill_q <= 1'b0;
                    if (launch) begin
                        state_q <= ST_WAIT;
                        remain  <= count_cfg;
                    end
                end
                ST_WAIT: begin
                    if (kill)            state_q <= ST_IDLE;
                    else if (pace_ready) state_q <= ST_READ;
                end
                ST_READ: begin
                    if (kill) kill_q <= 1'b1;
                    if (m_ack) begin
                        hold_q  <= m_rdata;
                        state_q <= stopping ? ST_IDLE : ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (kill) kill_q <= 1'b1;
                    if (m_ack) begin
                        src_ptr  <= next_ptr(src_ptr, ctrl.size, ctrl.src_inc,
                                             !ctrl.ring_dst, ctrl.ring_log2);
                        dst_ptr  <= next_ptr(dst_ptr, ctrl.size, ctrl.dst_inc,
                                             ctrl.ring_dst, ctrl.ring_log2);
                        remain   <= remain - CNT_W'(1);
                        finished <= last_item && !stopping;
                        state_q  <= (last_item || stopping) ? ST_IDLE : ST_WAIT;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy    = state_q != ST_IDLE;
    assign m_req   = state_q == ST_READ || state_q == ST_WRITE;
    assign m_we    = state_q == ST_WRITE;
    assign m_addr  = (state_q == ST_WRITE) ? dst_ptr : src_ptr;
    assign m_size  = ctrl.size;
    assign m_wdata = hold_q;
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int CH_ID = 0,
    parameter int NDREQ = 59,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              busy,
    input  logic              chain_in,
    output logic              chain_valid,
    output logic [3:0]        chain_id,
    output logic              done_irq,
    input  logic [NDREQ-1:0]  dreq,
    input  logic [3:0]        timer_req,
    output logic              m_req,
    output logic              m_we,
    output logic [31:0]       m_addr,
    output logic [1:0]        m_size,
    output logic [31:0]       m_wdata,
    input  logic              m_ack,
    input  logic [31:0]       m_rdata
);
    localparam int PAD_W = DATA_W - CTRL_W - 1;

    mover_ctrl_t       ctrl;
    logic [CNT_W-1:0]  count_cfg;
    logic [CNT_W-1:0]  work_cnt;
    logic [ADDR_W-1:0] src_ptr, dst_ptr;
    logic              load_src, load_dst, go_sw, kill;
    logic              pace_ready, consume, finished;

    dmac_cfg #(.CH_ID(CH_ID), .CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst(rst), .we(reg_we), .idx(reg_addr), .wdata(reg_wdata),
        .busy(busy), .ctrl(ctrl), .count_cfg(count_cfg), .load_src(load_src),
        .load_dst(load_dst), .go_sw(go_sw), .kill(kill)
    );

    dmac_pace #(.NDREQ(NDREQ)) u_pace (
        .clk(clk), .rst(rst), .sel(ctrl.pace), .dreq(dreq), .ticks(timer_req),
        .busy(busy), .consume(consume), .ready(pace_ready)
    );

    dmac_xfer #(.CNT_W(CNT_W)) u_xfer (
        .clk(clk), .rst(rst), .ctrl(ctrl), .count_cfg(count_cfg),
        .load_src(load_src), .load_dst(load_dst), .ptr_wdata(reg_wdata),
        .go_sw(go_sw), .go_chain(chain_in), .kill(kill), .pace_ready(pace_ready),
        .m_ack(m_ack), .m_rdata(m_rdata), .busy(busy), .src_ptr(src_ptr),
        .dst_ptr(dst_ptr), .remain(work_cnt), .m_req(m_req), .m_we(m_we),
        .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata),
        .consume(consume), .finished(finished)
    );

    assign chain_valid = finished && ctrl.next_ch != 4'(CH_ID);
    assign chain_id    = ctrl.next_ch;
    assign done_irq    = finished && !ctrl.quiet;

    always_comb begin
        case (reg_addr)
            IDX_SRC, IDX_GO: reg_rdata = src_ptr;
            IDX_DST:         reg_rdata = dst_ptr;
            IDX_COUNT:       reg_rdata = DATA_W'(count_cfg);
            IDX_CTRL:        reg_rdata = {busy, {PAD_W{1'b0}}, ctrl};
            IDX_REMAIN:      reg_rdata = DATA_W'(work_cnt);
            default:         reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmac_chan_chk.sv
module dmac_chan_chk #(
    parameter int CH_ID = 0,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             m_req,
    input logic             m_we,
    input logic             m_ack,
    input logic [31:0]      m_addr,
    input logic             chain_valid,
    input logic [3:0]       chain_id,
    input logic [CNT_W-1:0] remain
);
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        m_req && !m_ack |=> m_req && $stable(m_addr) && $stable(m_we));

    assert_access_busy_R2: assert property (@(posedge clk) disable iff (rst)
        m_req |-> busy);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        m_req && m_we && m_ack |=> remain == CNT_W'($past(remain) - 1'b1));

    assert_read_before_write_R3: assert property (@(posedge clk) disable iff (rst)
        m_req && m_we && m_ack |=> !(m_req && m_we));

    assert_chain_not_self_R6: assert property (@(posedge clk) disable iff (rst)
        chain_valid |-> chain_id != 4'(CH_ID));

    assert_chain_single_R6: assert property (@(posedge clk) disable iff (rst)
        chain_valid |=> !chain_valid);
endmodule

bind dmac_chan dmac_chan_chk #(.CH_ID(CH_ID), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .m_req(m_req), .m_we(m_we),
    .m_ack(m_ack), .m_addr(m_addr), .chain_valid(chain_valid),
    .chain_id(chain_id), .remain(work_cnt)
);

// File: tb/dmac_chan_tb.sv
`timescale 1ns/1ps
module dmac_chan_tb;
    localparam int NDREQ = 59;
    localparam int MSZ   = 512;
    localparam int SELF  = 2;

    logic clk = 0, rst = 1;
    logic reg_we = 0;
    logic [2:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic busy, chain_in = 0, chain_valid, done_irq;
    logic [3:0] chain_id;
    logic [NDREQ-1:0] dreq = '0;
    logic [3:0] timer_req = '0;
    logic m_req, m_we, m_ack;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic [1:0] m_size;

    logic [7:0] mem [MSZ];
    logic [7:0] expm [MSZ];
    int vectors = 0, miscompares = 0;
    int chain_cnt, irq_cnt;
    logic [3:0] chain_last;

    always #2.5 clk = ~clk;

    dmac_chan #(.CH_ID(SELF), .NDREQ(NDREQ)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .chain_in(chain_in), .chain_valid(chain_valid), .chain_id(chain_id),
        .done_irq(done_irq), .dreq(dreq), .timer_req(timer_req),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_size(m_size),
        .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata)
    );

    // bus responder: one-cycle latency, right-aligned data
    always @(posedge clk) begin
        if (rst) begin
            m_ack   <= 1'b0;
            m_rdata <= '0;
        end else if (m_req && !m_ack) begin
            automatic int n = (m_size == 0) ? 1 : (m_size == 1) ? 2 : 4;
            automatic logic [31:0] r = '0;
            m_ack <= 1'b1;
            for (int b = 0; b < n; b++) begin
                if (m_we) mem[(m_addr + b) % MSZ] <= m_wdata[8*b +: 8];
                else      r[8*b +: 8] = mem[(m_addr + b) % MSZ];
            end
            m_rdata <= r;
        end else begin
            m_ack <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            chain_cnt <= 0; irq_cnt <= 0; chain_last <= '0;
        end else begin
            if (chain_valid) begin chain_cnt <= chain_cnt + 1; chain_last <= chain_id; end
            if (done_irq) irq_cnt <= irq_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] mk_ctrl(input int en, size, sinc, dinc, ring,
                                            rdst, nxt, pace, quiet);
        return 32'(en) | 32'(size) << 1 | 32'(sinc) << 3 | 32'(dinc) << 4 |
               32'(ring) << 5 | 32'(rdst) << 9 | 32'(nxt) << 10 |
               32'(pace) << 14 | 32'(quiet) << 20;
    endfunction

    function automatic logic [31:0] adv(input logic [31:0] a, input int n,
                                        input int inc, input int wrap, input int ring);
        logic [31:0] win, base;
        if (inc == 0) return a;
        if (wrap != 0 && ring != 0) begin
            win  = 32'd1 << ring;
            base = a - (a % win);
            return base + ((a - base + n) % win);
        end
        return a + n;
    endfunction

    task automatic fill_mem();
        for (int i = 0; i < MSZ; i++) begin
            mem[i]  = 8'(i * 37 + 11);
            expm[i] = 8'(i * 37 + 11);
        end
    endtask

    task automatic model(inout logic [31:0] sa, inout logic [31:0] da, input int cnt,
                         input int size, sinc, dinc, ring, rdst);
        int n;
        logic [7:0] t [4];
        n = (size == 0) ? 1 : (size == 1) ? 2 : 4;
        for (int i = 0; i < cnt; i++) begin
            for (int b = 0; b < n; b++) t[b] = expm[(sa + b) % MSZ];
            for (int b = 0; b < n; b++) expm[(da + b) % MSZ] = t[b];
            sa = adv(sa, n, sinc, rdst == 0 ? 1 : 0, ring);
            da = adv(da, n, dinc, rdst, ring);
        end
    endtask

    task automatic wait_idle(input string req);
        int k = 0;
        while (busy && k < 20000) begin @(negedge clk); k++; end
        if (busy) chk({req, " timeout"}, 1, 0);
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0;
        for (int i = 0; i < MSZ; i++) if (mem[i] !== expm[i]) bad++;
        chk({req, " memory bytes"}, 32'(bad), 0);
    endtask

    task automatic run_one(input logic [31:0] s0, d0, input int cnt, size, sinc, dinc,
                           ring, rdst, input string req);
        logic [31:0] sa, da, v;
        sa = s0; da = d0;
        model(sa, da, cnt, size, sinc, dinc, ring, rdst);
        wr_reg(3'd1, d0);
        wr_reg(3'd2, 32'(cnt));
        wr_reg(3'd3, mk_ctrl(1, size, sinc, dinc, ring, rdst, SELF, 63, 0));
        wr_reg(3'd4, s0);
        wait_idle(req);
        cmp_mem(req);
        rd_reg(3'd0, v); chk({req, " src end"}, v, sa);
        rd_reg(3'd1, v); chk({req, " dst end"}, v, da);
        rd_reg(3'd6, v); chk({req, " remain"}, v, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] v, sa, da;
        int c0, i0;
        fill_mem();
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            if (a == 5) continue;
            rd_reg(3'(a), v); chk("R1 register reset", v, 0);
        end
        chk("R1 busy", 32'(busy), 0);
        chk("R1 m_req", 32'(m_req), 0);

        // R3 R4 R5 sweep of size, increments and ring side
        for (int sz = 0; sz < 3; sz++)
            for (int im = 1; im < 4; im++)
                for (int rg = 0; rg < 3; rg++) begin
                    fill_mem();
                    run_one(32'h40, 32'h100, 5, sz, im & 1, im >> 1,
                            rg == 0 ? 0 : 3, rg == 2 ? 1 : 0, "R3 R4 R5 sweep");
                end
        // R5 ring widths
        for (int rl = 1; rl < 8; rl++) begin
            fill_mem();
            run_one(32'h80, 32'h180, 9, 1, 1, 1, rl, rl & 1, "R5 ring width");
        end

        // R2 zero count and disabled channel
        wr_reg(3'd2, 0);
        wr_reg(3'd3, mk_ctrl(1, 0, 1, 1, 0, 0, SELF, 63, 0));
        wr_reg(3'd4, 32'h10);
        chk("R2 zero count no start", 32'(busy), 0);
        wr_reg(3'd2, 3);
        wr_reg(3'd3, mk_ctrl(0, 0, 1, 1, 0, 0, SELF, 63, 0));
        wr_reg(3'd4, 32'h10);
        chk("R2 disabled no start", 32'(busy), 0);

        // R6 chaining to another channel, irq
        c0 = chain_cnt; i0 = irq_cnt;
        wr_reg(3'd1, 32'h120); wr_reg(3'd2, 2);
        wr_reg(3'd3, mk_ctrl(1, 2, 1, 1, 0, 0, 5, 63, 0));
        wr_reg(3'd4, 32'h20);
        wait_idle("R6");
        @(negedge clk);
        chk("R6 chain pulse count", 32'(chain_cnt - c0), 1);
        chk("R6 chain id", 32'(chain_last), 5);
        chk("R6 irq pulse", 32'(irq_cnt - i0), 1);
        // R6 self chain, quiet
        c0 = chain_cnt; i0 = irq_cnt;
        wr_reg(3'd3, mk_ctrl(1, 2, 1, 1, 0, 0, SELF, 63, 1));
        wr_reg(3'd4, 32'h20);
        wait_idle("R6 self");
        @(negedge clk);
        chk("R6 no self chain", 32'(chain_cnt - c0), 0);
        chk("R6 quiet irq", 32'(irq_cnt - i0), 0);

        // R7 R11 chain_in triggers, pointers resume, count reloads
        fill_mem();
        wr_reg(3'd0, 32'h30); wr_reg(3'd1, 32'h140); wr_reg(3'd2, 3);
        wr_reg(3'd3, mk_ctrl(1, 1, 1, 1, 0, 0, SELF, 63, 0));
        sa = 32'h30; da = 32'h140;
        model(sa, da, 6, 1, 1, 1, 0, 0);
        for (int r = 0; r < 2; r++) begin
            @(negedge clk); chain_in = 1; @(negedge clk); chain_in = 0;
            chk("R7 chain_in starts", 32'(busy), 1);
            wait_idle("R7");
        end
        cmp_mem("R11 resumed pointers");
        rd_reg(3'd0, v); chk("R11 src resumed", v, sa);

        // R8 timer pacing
        wr_reg(3'd2, 3);
        wr_reg(3'd3, mk_ctrl(1, 0, 1, 1, 0, 0, SELF, 6'h3c, 0));
        wr_reg(3'd4, 32'h10);
        repeat (20) @(negedge clk);
        rd_reg(3'd6, v); chk("R8 no tick no item", v, 3);
        @(negedge clk); timer_req = 4'b0001; @(negedge clk); timer_req = 0;
        repeat (10) @(negedge clk);
        rd_reg(3'd6, v); chk("R8 wrong timer ignored", v, 3);
        for (int t = 0; t < 3; t++) begin
            @(negedge clk); timer_req = 4'b0010; @(negedge clk); timer_req = 0;
            repeat (10) @(negedge clk);
            rd_reg(3'd6, v); chk("R8 one item per tick", v, 32'(2 - t));
        end
        chk("R8 timer run done", 32'(busy), 0);

        // R8 level request on highest line
        fill_mem();
        dreq[58] = 1'b1;
        run_one(32'h60, 32'h1a0, 4, 2, 1, 1, 0, 0, "R8 dreq line");
        dreq[58] = 1'b0;

        // R10 R9 ignored writes and abort
        c0 = chain_cnt; i0 = irq_cnt;
        wr_reg(3'd0, 32'h44); wr_reg(3'd2, 4);
        wr_reg(3'd3, mk_ctrl(1, 0, 1, 1, 0, 0, 5, 7, 0));
        wr_reg(3'd4, 32'h44);
        wr_reg(3'd0, 32'h1ff);
        rd_reg(3'd0, v); chk("R10 src write while busy", v, 32'h44);
        wr_reg(3'd2, 9);
        rd_reg(3'd2, v); chk("R10 count write while busy", v, 4);
        rd_reg(3'd3, v); chk("R10 busy bit", v >> 31, 1);
        wr_reg(3'd5, 32'h8);
        chk("R9 other channel bit no effect", 32'(busy), 1);
        wr_reg(3'd5, 32'h4);
        chk("R9 abort stops", 32'(busy), 0);
        rd_reg(3'd6, v); chk("R9 remain after abort", v, 4);
        chk("R9 no chain on abort", 32'(chain_cnt - c0), 0);
        chk("R9 no irq on abort", 32'(irq_cnt - i0), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule